// File: doc/BRIEF.md
# SD Card SPI-Mode Command Framer

This block issues one command to an SD or MMC card running in SPI mode and returns the card's one-byte R1 reply. A controller supplies a 6-bit command index, a 32-bit argument and a flag that marks the command as an application command, then pulses `start_i`. The block drives the card's active-low chip select and moves every byte through a simple byte-level SPI master: it presents a byte with a one-cycle `spi_start_o` pulse and waits for `spi_done_i`, which returns the byte clocked in from the card.

Each frame starts with a select cycle: chip select released with one 0xFF fill byte, then chip select asserted with a second fill byte. Six frame bytes follow: a header byte (0x40 OR'd with the index), the argument most significant byte first, and a CRC/stop byte. The block then polls with 0xFF bytes until the card answers. An application command is preceded automatically by a CMD55 frame with a zero argument. If that prefix is refused, the block reports the refusal and does not send the main command. Chip select stays low at the end, so a downstream engine can collect any trailing reply or data bytes.

The controller is a single state machine with six states. `ST_IDLE` waits for a start. `ST_DESEL` sends the fill byte with select released. `ST_SEL` sends the fill byte with select asserted. `ST_FRAME` sends the six frame bytes. `ST_POLL` reads reply bytes. `ST_DONE` gives the completion pulse. Its transitions:
- IDLE→DESEL on start.
- DESEL→SEL, SEL→FRAME, and FRAME→POLL after the sixth byte, each on a completed byte.
- POLL→DESEL when an accepted CMD55 prefix hands over to the main command.
- POLL→DONE on a final reply or a refused prefix.
- DONE→IDLE unconditionally.

Top module: `sd_cmd_framer`

## Requirements
- R1: After reset, `cs_n_o` is 1, `spi_start_o` is 0 and `done_o` is 0.
- R2: Every frame is preceded by one 0xFF byte exchanged with `cs_n_o`=1, then one 0xFF byte exchanged with `cs_n_o`=0. `cs_n_o` never changes while a byte exchange is outstanding.
- R3: The six frame bytes are sent with `cs_n_o`=0 in this order: 0x40 | index, argument bits 31:24, 23:16, 15:8, 7:0, then the CRC byte.
- R4: The CRC byte is 0x95 for index 0, 0x87 for index 8 and 0x01 for every other index.
- R5: After the frame, bytes of 0xFF are exchanged to poll. Polling stops at the first received byte with bit 7 clear, and never exceeds 10 exchanges.
- R6: `resp_o` holds the last byte received. `timeout_o` is 1 exactly when that byte has bit 7 set, so after 10 busy bytes the tenth is returned with `timeout_o`=1.
- R7: With `app_i`=1, a CMD55 frame (index 55, argument 0, CRC 0x01) is sent first. If its reply is 0 or 1, the requested command frame follows with its own select cycle.
- R8: If the CMD55 reply is greater than 1 (including a timed-out reply), the block completes with that reply and sends no further bytes.
- R9: Exactly one `spi_start_o` pulse is issued per byte, and no new pulse is issued before `spi_done_i` has answered the previous one.
- R10: `cs_n_o` remains 0 when `done_o` pulses and while idle afterwards.
- R11: `start_i` pulses while a command is in progress are ignored.
- R12: `done_o` is a single-cycle pulse. `resp_o` and `timeout_o` hold their values until the next command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| cmd_idx_i | input | 6 | Command index |
| app_i | input | 1 | Send a CMD55 prefix first |
| arg_i | input | 32 | Command argument |
| spi_start_o | output | 1 | One-cycle request to exchange `spi_tx_o` |
| spi_tx_o | output | 8 | Byte to transmit |
| spi_rx_i | input | 8 | Byte received, valid with `spi_done_i` |
| spi_done_i | input | 1 | Byte exchange complete |
| cs_n_o | output | 1 | Card chip select, active low |
| done_o | output | 1 | Completion pulse |
| resp_o | output | 8 | Reply byte |
| timeout_o | output | 1 | Reply still had bit 7 set |

## Verification
The hardest case to reach from the ports is the application-command hand-over. The main frame must follow only when the CMD55 reply is at most 1, and the CMD55 reply itself may arrive on any of the ten polls or never arrive. The bench models the SPI master and scripts each frame's reply separately: a number of busy bytes (0x80 plus the poll number) followed by a chosen reply value. It then sweeps both frames over short, mid-length and timed-out delays, crossed with accepting and refusing replies. It also varies the master's latency byte by byte, so that the handshake and chip-select stability are tested under uneven timing.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESEL,
        ST_SEL,
        ST_FRAME,
        ST_POLL,
        ST_DONE
    } sdcf_state_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam logic [1:0] START_BITS = 2'b01;
endpackage

// File: rtl/sdcf_crc_sel.sv
module sdcf_crc_sel #(
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned RESET_IDX  = 0,
    parameter int unsigned IFCOND_IDX = 8,
    parameter logic [7:0]  CRC_RESET  = 8'h95,
    parameter logic [7:0]  CRC_IFCOND = 8'h87,
    parameter logic [7:0]  CRC_DUMMY  = 8'h01
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       crc_o
);
    always_comb begin
        if (idx_i == IDX_W'(RESET_IDX))
            crc_o = CRC_RESET;
        else if (idx_i == IDX_W'(IFCOND_IDX))
            crc_o = CRC_IFCOND;
        else
            crc_o = CRC_DUMMY;
    end
endmodule

// File: rtl/sdcf_frame_mux.sv
module sdcf_frame_mux
    import sdcf_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned ARG_W = 32,
    localparam int unsigned ARG_BYTES = ARG_W / 8,
    localparam int unsigned FRAME_BYTES = ARG_BYTES + 2,
    localparam int unsigned SEL_W = $clog2(FRAME_BYTES)
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [ARG_W-1:0] arg_i,
    input  logic [7:0]       crc_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [7:0]       byte_o
);
    logic [7:0] slot [FRAME_BYTES];

    assign slot[0] = {START_BITS, idx_i};
    assign slot[FRAME_BYTES-1] = crc_i;

    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
        assign slot[g+1] = arg_i[ARG_W-1-8*g -: 8];
    end

    always_comb begin
        byte_o = FILL_BYTE;
        for (int k = 0; k < FRAME_BYTES; k++) begin
            if (sel_i == SEL_W'(k))
                byte_o = slot[k];
        end
    end
endmodule

// File: rtl/sdcf_poll_tracker.sv
module sdcf_poll_tracker #(
    parameter int unsigned LIMIT = 10,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [7:0] rx_i,
    output logic       stop_o
);
    logic [CNT_W-1:0] tries_q;

    assign stop_o = step_i && (!rx_i[7] || (tries_q == CNT_W'(LIMIT - 1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tries_q <= '0;
        else if (clear_i || stop_o)
            tries_q <= '0;
        else if (step_i)
            tries_q <= tries_q + 1'b1;
    end

    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < CNT_W'(LIMIT));
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
    import sdcf_pkg::*;
#(
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned ARG_W      = 32,
    parameter int unsigned POLL_LIMIT = 10,
    parameter int unsigned APP_IDX    = 55,
    localparam int unsigned FRAME_BYTES = ARG_W / 8 + 2,
    localparam int unsigned SEL_W = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] cmd_idx_i,
    input  logic             app_i,
    input  logic [ARG_W-1:0] arg_i,
    output logic             spi_start_o,
    output logic [7:0]       spi_tx_o,
    input  logic [7:0]       spi_rx_i,
    input  logic             spi_done_i,
    output logic             cs_n_o,
    output logic             done_o,
    output logic [7:0]       resp_o,
    output logic             timeout_o
);
    sdcf_state_e      state_q;
    logic             inflight_q;
    logic [SEL_W-1:0] sel_q;
    logic             cs_n_q;
    logic             prefix_q;
    logic [IDX_W-1:0] cmd_q;
    logic [ARG_W-1:0] arg_q;
    logic [7:0]       resp_q;
    logic             to_q;

    logic [IDX_W-1:0] cur_idx;
    logic [ARG_W-1:0] cur_arg;
    logic [7:0]       crc_byte;
    logic [7:0]       frame_byte;
    logic             xfer_end;
    logic             poll_step;
    logic             poll_stop;

    assign cur_idx   = prefix_q ? IDX_W'(APP_IDX) : cmd_q;
    assign cur_arg   = prefix_q ? '0 : arg_q;
    assign xfer_end  = inflight_q && spi_done_i;
    assign poll_step = (state_q == ST_POLL) && xfer_end;

    sdcf_crc_sel #(.IDX_W(IDX_W)) u_crc (
        .idx_i (cur_idx),
        .crc_o (crc_byte)
    );

    sdcf_frame_mux #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_mux (
        .idx_i  (cur_idx),
        .arg_i  (cur_arg),
        .crc_i  (crc_byte),
        .sel_i  (sel_q),
        .byte_o (frame_byte)
    );

    sdcf_poll_tracker #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q != ST_POLL),
        .step_i  (poll_step),
        .rx_i    (spi_rx_i),
        .stop_o  (poll_stop)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            inflight_q <= 1'b0;
            sel_q      <= '0;
            cs_n_q     <= 1'b1;
            prefix_q   <= 1'b0;
            cmd_q      <= '0;
            arg_q      <= '0;
            resp_q     <= '0;
            to_q       <= 1'b0;
        end else begin
            if (spi_start_o)
                inflight_q <= 1'b1;
            else if (spi_done_i)
                inflight_q <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cmd_q    <= cmd_idx_i;
                        arg_q    <= arg_i;
                        prefix_q <= app_i;
                        cs_n_q   <= 1'b1;
                        state_q  <= ST_DESEL;
                    end
                end
                ST_DESEL: begin
                    if (xfer_end) begin
                        cs_n_q  <= 1'b0;
                        state_q <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (xfer_end) begin
                        sel_q   <= '0;
                        state_q <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (xfer_end) begin
                        if (sel_q == SEL_W'(FRAME_BYTES - 1))
                            state_q <= ST_POLL;
                        else
                            sel_q <= sel_q + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (poll_stop) begin
                        resp_q <= spi_rx_i;
                        if (prefix_q && spi_rx_i <= 8'd1) begin
                            prefix_q <= 1'b0;
                            cs_n_q   <= 1'b1;
                            state_q  <= ST_DESEL;
                        end else begin
                            to_q    <= spi_rx_i[7];
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        spi_start_o = 1'b0;
        spi_tx_o    = FILL_BYTE;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DESEL, ST_SEL, ST_POLL: spi_start_o = !inflight_q;
            ST_FRAME: begin
                spi_start_o = !inflight_q;
                spi_tx_o    = frame_byte;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign cs_n_o    = cs_n_q;
    assign resp_o    = resp_q;
    assign timeout_o = to_q;

    // R9
    one_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start_o |=> !spi_start_o);
    // R2
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> $stable(cs_n_o));
    // R10
    hold_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cs_n_o);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (timeout_o == resp_o[7]));
    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cmd_q) && $stable(arg_q));
    // R3
    frame_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME) |-> (sel_q < SEL_W'(FRAME_BYTES)));
endmodule

// File: tb/sd_cmd_framer_tb.sv
module sd_cmd_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOGN = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  cmd_i = '0;
    logic        app_i = 1'b0;
    logic [31:0] arg_i = '0;
    logic        spi_start_o;
    logic [7:0]  spi_tx_o;
    logic [7:0]  spi_rx_i;
    logic        spi_done_i;
    logic        cs_n_o, done_o, timeout_o;
    logic [7:0]  resp_o;
    logic        clr = 1'b0;

    int vectors = 0;
    int misses = 0;

    // reply script: per frame, busy byte count and final value
    int d_first = 0, d_second = 0;
    logic [7:0] v_first = 0, v_second = 0;

    // SPI master model log
    logic [7:0] log_tx [LOGN];
    logic       log_cs [LOGN];
    int nlog = 0, frame_no = 0, pos = 0, pend = 0, overlap = 0;
    logic [7:0] cur_rx = 8'hFF;

    logic [7:0] exp_tx [LOGN];
    logic       exp_cs [LOGN];
    string      exp_tag [LOGN];
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_cmd_framer u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_idx_i(cmd_i),
        .app_i(app_i), .arg_i(arg_i), .spi_start_o(spi_start_o),
        .spi_tx_o(spi_tx_o), .spi_rx_i(spi_rx_i), .spi_done_i(spi_done_i),
        .cs_n_o(cs_n_o), .done_o(done_o), .resp_o(resp_o), .timeout_o(timeout_o)
    );

    always @(posedge clk) begin
        if (!rst_n || clr) begin
            nlog = 0; frame_no = 0; pos = 0; pend = 0; overlap = 0;
            spi_done_i <= 1'b0;
            spi_rx_i <= 8'hFF;
        end else begin
            spi_done_i <= 1'b0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) begin
                    spi_done_i <= 1'b1;
                    spi_rx_i <= cur_rx;
                end
            end
            if (spi_start_o) begin
                if (pend != 0 || spi_done_i) overlap++;
                if (cs_n_o) begin frame_no++; pos = 0; end
                else pos++;
                if (nlog < LOGN) begin
                    log_tx[nlog] = spi_tx_o;
                    log_cs[nlog] = cs_n_o;
                end
                nlog++;
                if (pos < 8) cur_rx = 8'hFF;
                else if ((pos - 8) < ((frame_no == 1) ? d_first : d_second))
                    cur_rx = 8'h80 | 8'(pos - 8);
                else
                    cur_rx = (frame_no == 1) ? v_first : v_second;
                pend = 1 + (nlog % 3);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        misses++;
        $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic cs, input string tag);
        exp_tx[exp_n] = b; exp_cs[exp_n] = cs; exp_tag[exp_n] = tag; exp_n++;
    endtask

    task automatic add_frame(input int idx, input logic [31:0] a, input int d,
                             input logic [7:0] v, output logic [7:0] r);
        int np;
        push(8'hFF, 1'b1, "R2");
        push(8'hFF, 1'b0, "R2");
        push(8'h40 | 8'(idx), 1'b0, "R3");
        for (int k = 3; k >= 0; k--) push(a[8*k +: 8], 1'b0, "R3");
        push(idx == 0 ? 8'h95 : (idx == 8 ? 8'h87 : 8'h01), 1'b0, "R4");
        np = (d >= 10) ? 10 : d + 1;
        for (int k = 0; k < np; k++) push(8'hFF, 1'b0, "R5");
        r = (d >= 10) ? 8'h89 : v;
    endtask

    task automatic run(input int idx, input bit app, input logic [31:0] a,
                       input int d0, input logic [7:0] v0,
                       input int d1, input logic [7:0] v1, input bit poke);
        logic [7:0] r, er;
        string rtag;
        int w;
        exp_n = 0;
        rtag = app ? "R7" : "R5";
        if (app) begin
            add_frame(55, 32'h0, d0, v0, r);
            if (r > 1) begin er = r; rtag = "R8"; end
            else add_frame(idx, a, d1, v1, er);
        end else add_frame(idx, a, d0, v0, er);

        @(negedge clk);
        clr = 1'b1; d_first = d0; d_second = d1; v_first = v0; v_second = v1;
        @(negedge clk);
        clr = 1'b0;
        cmd_i = 6'(idx); app_i = app; arg_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            cmd_i = ~cmd_i; arg_i = ~arg_i; app_i = ~app_i; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        w = 0;
        while (!done_o && w < 2000) begin @(negedge clk); w++; end
        check(done_o == 1'b1, "R12", "done seen", done_o, 1);
        check(resp_o == er, rtag, "response", resp_o, er);
        check(timeout_o == er[7], "R6", "timeout flag", timeout_o, er[7]);
        check(cs_n_o == 1'b0, "R10", "cs at done", cs_n_o, 0);
        check(overlap == 0, "R9", "start before done", overlap, 0);
        check(nlog == exp_n, poke ? "R11" : (app ? "R8" : "R5"), "byte count", nlog, exp_n);
        for (int k = 0; k < exp_n && k < nlog && k < LOGN; k++) begin
            check(log_tx[k] == exp_tx[k], exp_tag[k], "tx byte", log_tx[k], exp_tx[k]);
            check(log_cs[k] == exp_cs[k], "R2", "cs during byte", log_cs[k], exp_cs[k]);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R12", "done width", done_o, 0);
        repeat (4) @(negedge clk);
        check(resp_o == er, "R12", "response held", resp_o, er);
        check(cs_n_o == 1'b0 && nlog == exp_n, "R10", "idle keeps select, no bytes",
              nlog, exp_n);
    endtask

    initial begin
        int dl [3];
        logic [7:0] vl [4];
        dl = '{0, 4, 11};
        vl = '{8'h00, 8'h01, 8'h02, 8'h05};
        repeat (3) @(negedge clk);
        check(cs_n_o == 1'b1, "R1", "reset cs", cs_n_o, 1);
        check(spi_start_o == 1'b0, "R1", "reset spi start", spi_start_o, 0);
        check(done_o == 1'b0, "R1", "reset done", done_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n_o == 1'b1 && spi_start_o == 1'b0, "R1", "idle after reset",
              spi_start_o, 0);

        // plain commands: every index, poll delays 0..11 (R3 R4 R5 R6)
        for (int i = 0; i < 64; i++)
            run(i, 1'b0, (32'(i) * 32'h01020305) ^ 32'hA5C3_1E78, i % 12,
                8'(i) & 8'h7F, 0, 8'h00, 1'b0);
        run(8, 1'b0, 32'h0000_01AA, 2, 8'h01, 0, 8'h00, 1'b0);
        run(0, 1'b0, 32'h0, 9, 8'h01, 0, 8'h00, 1'b0);

        // application commands: prefix outcome x main outcome (R7 R8)
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 3; c++)
                    run(41, 1'b1, 32'h4000_0000, dl[a], vl[b], dl[c], 8'h00, 1'b0);

        // start pulses while busy are ignored (R11)
        run(17, 1'b0, 32'h0000_0200, 5, 8'h00, 0, 8'h00, 1'b1);
        run(23, 1'b1, 32'h1234_5678, 3, 8'h01, 10, 8'h00, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule